// File: doc/BRIEF.md
# Dual-Bank Interrupt Mask and Vector Unit

This unit collects sixteen edge-triggered interrupt lines into one request signal for a processor. The lines form two banks of eight, low (lines 0 to 7) and high (lines 8 to 15). Each bank has two byte-wide registers. One is an end-of-interrupt command register. The other is a mask register. A mask byte is written with a one meaning "masked", and the unit stores its complement as enable bits.

A rising edge on a line latches a pending bit. That bit stays set until software writes the command register of its bank, and that write clears every pending bit in the bank at once. The combined request output is high while any line is both pending and enabled. A vector register gives software the lowest-numbered line that is pending and enabled.

Register access uses one small address bus with a write strobe. Read data is combinational from the address. Reads have no side effects.

Top module: `isa_irq_vec_unit`

## Requirements
- R1: Reset (synchronous, active low) sets all sixteen enable bits to one, clears every pending bit and drives `irq_out` low.
- R2: A low-to-high transition of `irq_in[i]`, seen at a clock edge, sets pending bit i from that edge on. A line that stays high does not set its bit again after the bit has been cleared.
- R3: A write to address 1 (low mask) stores the inverse of `wr_data` into enable bits 7:0 and leaves enable bits 15:8 unchanged.
- R4: A write to address 3 (high mask) stores the inverse of `wr_data` into enable bits 15:8 and leaves enable bits 7:0 unchanged.
- R5: A write to address 0 (low command) clears pending bits 7:0, whatever the data value, and leaves pending bits 15:8 unchanged.
- R6: A write to address 2 (high command) clears pending bits 15:8, whatever the data value, and leaves pending bits 7:0 unchanged.
- R7: A read of address 1 or address 3 returns the full 16-bit enable register on `rd_data`.
- R8: A read of address 4 returns, in `rd_data[3:0]` with upper bits zero, the index of the lowest set bit of (pending AND enable). It returns 0 when that set is empty.
- R9: `irq_out` is high exactly when (pending AND enable) is nonzero. Masking a line hides its pending bit but does not discard it, so unmasking raises the request again.
- R10: When a rising edge and a command write to the same bank fall in the same cycle, the newly edged line stays pending and the bank's other pending bits are cleared.
- R11: Writes to address 4 and to addresses 5 to 7 change nothing. Reads of addresses 0, 2 and 5 to 7 return 0 and clear nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Interrupt lines, rising-edge sensitive |
| reg_addr | input | 3 | Register address (0 low cmd, 1 low mask, 2 high cmd, 3 high mask, 4 vector) |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 16 | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Combined request: any line pending and enabled |

## Verification
Two functions can land on the same edge. One is the setting of a pending bit by a new input edge; the other is the bank-wide clear from a command write. The bench provokes this on the high bank. It keeps one line pending there, then in a single cycle raises a second line of that bank and writes the high command register. The result is judged through the vector and the request output after that edge: the fresh line must read back as the vector and the old line must be gone.

// File: rtl/isa_irq_pkg.sv
// Package: shared sizes for the dual-bank interrupt unit.
// Assumes two byte-wide banks. The register map is derived in the top module.
package isa_irq_pkg;
    localparam int BANK_BITS  = 8;
    localparam int BANK_COUNT = 2;
endpackage

// File: rtl/irq_edge_latch.sv
// irq_edge_latch: detects rising edges on each line and keeps a sticky pending bit.
// Assumes irq_in is already synchronous to clk. A set beats a clear in the same cycle.
module irq_edge_latch #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] clr_mask,
    output logic [LINES-1:0] pend_q
);
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] rise;

    // Purpose: lines that were low last cycle and are high now.
    always_comb rise = irq_in & ~prev_q;

    // Purpose: remember last sampled line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    // Purpose: sticky pending bits; a new edge survives a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | rise;
    end
endmodule

// File: rtl/irq_enable_reg.sv
// irq_enable_reg: per-bank enable bits, loaded with the inverse of a mask byte.
// Assumes at most one bank strobe is active per cycle. Resets to all enabled.
module irq_enable_reg #(
    parameter int BANK_W    = 8,
    parameter int NUM_BANKS = 2,
    localparam int LINES    = BANK_W * NUM_BANKS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_wr,
    input  logic [BANK_W-1:0]    wr_data,
    output logic [LINES-1:0]     enable_q
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Purpose: store the complemented mask byte into this bank's slice.
        always_ff @(posedge clk) begin
            if (!rst_n)          enable_q[b*BANK_W +: BANK_W] <= '1;
            else if (bank_wr[b]) enable_q[b*BANK_W +: BANK_W] <= ~wr_data;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
// irq_prio_enc: lowest-index priority encoder with an any-request flag.
// Returns index 0 when no request is set. The any flag tells that case apart.
module irq_prio_enc #(
    parameter int LINES = 16,
    localparam int VEC_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] req,
    output logic [VEC_W-1:0] vec,
    output logic             any
);
    // Purpose: scan from the top so the lowest set index is the last one written.
    always_comb begin
        vec = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (req[i]) vec = VEC_W'(i);
        end
    end

    // Purpose: flag any active request.
    always_comb any = |req;
endmodule

// File: rtl/isa_irq_vec_unit.sv
// isa_irq_vec_unit: two-bank interrupt collector with inverted mask writes,
// bank-wide end-of-interrupt clears and a lowest-index vector register.
// Register map: bank b has its command at 2b and its mask at 2b+1.
// The vector register sits at 2*NUM_BANKS. Reads are combinational.
module isa_irq_vec_unit #(
    parameter int BANK_W    = isa_irq_pkg::BANK_BITS,
    parameter int NUM_BANKS = isa_irq_pkg::BANK_COUNT,
    localparam int LINES    = BANK_W * NUM_BANKS,
    localparam int VEC_W    = $clog2(LINES),
    localparam int ADDR_W   = $clog2(2 * NUM_BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_data,
    output logic [LINES-1:0]  rd_data,
    output logic              irq_out
);
    localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(2 * NUM_BANKS);

    logic [NUM_BANKS-1:0] mask_wr;
    logic [LINES-1:0]     clr_mask;
    logic [LINES-1:0]     pend_q;
    logic [LINES-1:0]     enable_q;
    logic [LINES-1:0]     active;
    logic [VEC_W-1:0]     vec;
    logic                 any_active;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
        // Purpose: decode the write strobes for this bank's mask and command.
        always_comb begin
            mask_wr[b] = wr_en && (reg_addr == ADDR_W'(2 * b + 1));
            clr_mask[b*BANK_W +: BANK_W] = {BANK_W{wr_en && (reg_addr == ADDR_W'(2 * b))}};
        end
    end

    irq_edge_latch #(.LINES(LINES)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .clr_mask (clr_mask),
        .pend_q   (pend_q)
    );

    irq_enable_reg #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_wr  (mask_wr),
        .wr_data  (wr_data),
        .enable_q (enable_q)
    );

    // Purpose: lines both pending and enabled.
    always_comb active = pend_q & enable_q;

    irq_prio_enc #(.LINES(LINES)) u_prio (
        .req (active),
        .vec (vec),
        .any (any_active)
    );

    // Purpose: combined request output.
    always_comb irq_out = any_active;

    // Purpose: read mux; mask addresses return enable, vector returns index, rest zero.
    always_comb begin
        rd_data = '0;
        if (reg_addr == VEC_ADDR)
            rd_data = LINES'(vec);
        else if (reg_addr[0] && (reg_addr < VEC_ADDR))
            rd_data = enable_q;
    end
endmodule

// File: rtl/isa_irq_vec_chk.sv
// isa_irq_vec_chk: temporal checks bound into isa_irq_vec_unit.
// Assumes the default map: low cmd 0, low mask 1, high cmd 2, high mask 3, vector 4.
module isa_irq_vec_chk #(
    parameter int BANK_W = 8,
    parameter int LINES  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LINES-1:0]  irq_in,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wr_en,
    input logic [BANK_W-1:0] wr_data,
    input logic [LINES-1:0]  rd_data,
    input logic [LINES-1:0]  pend_q,
    input logic [LINES-1:0]  enable_q
);
    logic [LINES-1:0] act;
    always_comb act = pend_q & enable_q;

    // R3: low mask write loads inverse into low byte, high byte held
    p_low_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == ADDR_W'(1)) |=>
        (enable_q[BANK_W-1:0] == ~$past(wr_data)) &&
        (enable_q[LINES-1:BANK_W] == $past(enable_q[LINES-1:BANK_W])));

    // R4: high mask write loads inverse into high byte, low byte held
    p_high_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == ADDR_W'(3)) |=>
        (enable_q[LINES-1:BANK_W] == ~$past(wr_data)) &&
        (enable_q[BANK_W-1:0] == $past(enable_q[BANK_W-1:0])));

    // R5: after a low command write only lines high at that edge can be pending in the low bank
    p_low_eoi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == ADDR_W'(0)) |=>
        ((pend_q[BANK_W-1:0] & ~$past(irq_in[BANK_W-1:0])) == '0));

    // R6: same rule for the high bank
    p_high_eoi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == ADDR_W'(2)) |=>
        ((pend_q[LINES-1:BANK_W] & ~$past(irq_in[LINES-1:BANK_W])) == '0));

    // R2: without a command write no pending bit drops
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (reg_addr == ADDR_W'(0) || reg_addr == ADDR_W'(2))) |=>
        ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R8: vector names an active line with no lower active line
    p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(4) && act != '0) |->
        (act[rd_data[3:0]] && ((act & ((LINES'(1) << rd_data[3:0]) - LINES'(1))) == '0)));
endmodule

bind isa_irq_vec_unit isa_irq_vec_chk #(.BANK_W(BANK_W), .LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .reg_addr (reg_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .pend_q   (pend_q),
    .enable_q (enable_q)
);

// File: tb/isa_irq_vec_unit_bench.sv
// Bench: a table of steps walked by one loop, then directed reset and collision tests.
module isa_irq_vec_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_in;
    logic [2:0]  reg_addr;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic [15:0] rd_data;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    isa_irq_vec_unit u_isa_irq_vec_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq_out  (irq_out)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  waddr;
        logic [7:0]  wdata;
        logic [15:0] irq;
        logic [2:0]  raddr;
        logic [15:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEPS = 16;
    localparam step_t STEPS [NSTEPS] = '{
        '{1'b0, 3'd0, 8'h00, 16'h0000, 3'd4, 16'h0000, 1'b0, 4'd8},  // R8 nothing pending
        '{1'b0, 3'd0, 8'h00, 16'h0020, 3'd4, 16'h0005, 1'b1, 4'd2},  // R2 edge on line 5
        '{1'b0, 3'd0, 8'h00, 16'h8020, 3'd4, 16'h0005, 1'b1, 4'd8},  // R8 lowest wins
        '{1'b1, 3'd1, 8'h20, 16'h8020, 3'd1, 16'hFFDF, 1'b1, 4'd3},  // R3 mask line 5
        '{1'b0, 3'd0, 8'h00, 16'h8020, 3'd4, 16'h000F, 1'b1, 4'd9},  // R9 masked line hidden
        '{1'b1, 3'd3, 8'h80, 16'h8020, 3'd3, 16'h7FDF, 1'b0, 4'd4},  // R4 and R7
        '{1'b1, 3'd1, 8'h00, 16'h8020, 3'd4, 16'h0005, 1'b1, 4'd9},  // R9 unmask restores
        '{1'b1, 3'd0, 8'h20, 16'h8020, 3'd4, 16'h0000, 1'b0, 4'd5},  // R5 low clear
        '{1'b1, 3'd3, 8'h00, 16'h8020, 3'd4, 16'h000F, 1'b1, 4'd6},  // R6 high kept by low clear
        '{1'b1, 3'd2, 8'h5A, 16'h8020, 3'd4, 16'h0000, 1'b0, 4'd6},  // R6 high clear
        '{1'b0, 3'd0, 8'h00, 16'h8020, 3'd4, 16'h0000, 1'b0, 4'd2},  // R2 held level no reset
        '{1'b0, 3'd0, 8'h00, 16'h0101, 3'd4, 16'h0000, 1'b1, 4'd8},  // R8 line 0 gives vector 0
        '{1'b1, 3'd0, 8'h20, 16'h0101, 3'd4, 16'h0008, 1'b1, 4'd5},  // R5 only low bank cleared
        '{1'b1, 3'd4, 8'hFF, 16'h0101, 3'd1, 16'hFFFF, 1'b1, 4'd11}, // R11 write to vector
        '{1'b1, 3'd7, 8'hFF, 16'h0101, 3'd2, 16'h0000, 1'b1, 4'd11}, // R11 unmapped write
        '{1'b0, 3'd0, 8'h00, 16'h0101, 3'd6, 16'h0000, 1'b1, 4'd11}  // R11 unmapped read
    };

    task automatic check(input int req, input logic [15:0] act_rd, input logic [15:0] exp_rd,
                         input logic act_irq, input logic exp_irq);
        n_checks++;
        if (act_rd !== exp_rd) begin
            n_fail++;
            $display("FAIL R%0d rd_data actual=%h expected=%h", req, act_rd, exp_rd);
        end
        n_checks++;
        if (act_irq !== exp_irq) begin
            n_fail++;
            $display("FAIL R%0d irq_out actual=%b expected=%b", req, act_irq, exp_irq);
        end
    endtask

    // Drive an operation, let one edge pass, then present a read address and sample.
    task automatic run_step(input step_t s);
        @(negedge clk);
        wr_en    = s.wr;
        reg_addr = s.waddr;
        wr_data  = s.wdata;
        irq_in   = s.irq;
        @(negedge clk);
        wr_en    = 1'b0;
        reg_addr = s.raddr;
        #1;
        check(int'(s.req), rd_data, s.exp_rd, irq_out, s.exp_irq);
    endtask

    initial begin
        rst_n = 1'b0; irq_in = '0; reg_addr = '0; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen through mask reads and vector
        reg_addr = 3'd1; #1; check(1, rd_data, 16'hFFFF, irq_out, 1'b0);
        reg_addr = 3'd4; #1; check(1, rd_data, 16'h0000, irq_out, 1'b0);

        for (int k = 0; k < NSTEPS; k++) run_step(STEPS[k]);

        // R10: line 8 pending; raise line 9 and clear the high bank on the same edge
        @(negedge clk); irq_in = 16'h0000;
        @(negedge clk); irq_in = 16'h0200; wr_en = 1'b1; reg_addr = 3'd2; wr_data = 8'h20;
        @(negedge clk); wr_en = 1'b0; reg_addr = 3'd4; #1;
        check(10, rd_data, 16'h0009, irq_out, 1'b1);

        // R1: reset in mid-run restores enables and drops pending lines
        @(negedge clk); wr_en = 1'b1; reg_addr = 3'd3; wr_data = 8'hFF;
        @(negedge clk); wr_en = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; reg_addr = 3'd3; #1;
        check(1, rd_data, 16'hFFFF, irq_out, 1'b0);
        reg_addr = 3'd4; #1;
        check(1, rd_data, 16'h0000, irq_out, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule